// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block holds a bank of configuration registers. Each register keeps two copies: a staging copy and an active copy. Only the active copies drive the function outputs of the chip. A host port writes the staging copies. A small control register decides what happens next. In transparent mode, a write lands in both copies at once. In buffered mode, the function keeps running on the old active values until a commit copies every staging value into its active copy in a single clock.

A loader port serves the nonvolatile-memory reader. The loader fills staging copies one at a time and then commits the whole bank at once. The same path can restore the programmed settings after the host has experimented with new values. The control register also holds a page-erase enable, which gates erase requests before they reach the memory controller.

Top module: `cfg_bank_dbuf`

## Requirements
- R1: After reset, every staging and active copy reads 0x00, the transparent bit is 0 and the erase enable is 0.
- R2: With the transparent bit (control bit 0) at 1, a host register write updates both the staging and the active copy of the addressed register at the same clock edge.
- R3: With the transparent bit at 0, a host register write updates only the staging copy. The active copy keeps its old value.
- R4: A host write to the control register with bit 1 set copies all staging values into all active copies at that clock edge. The copy uses the staging values from before the edge. The same write stores bit 0 and bit 2.
- R5: Control bit 1 is never stored and always reads back as 0.
- R6: `erase_grant` equals `erase_req` AND control bit 2. With bit 2 at 0, no erase request passes.
- R7: A loader write updates only the staging copy of `ld_addr`, whatever the transparent bit says. A host register write in the same cycle is dropped entirely.
- R8: `ld_commit` copies all staging values into all active copies at that edge, in the same way as R4.
- R9: With `host_ctrl_sel` at 0, `host_rdata` returns the active copy of `host_addr`. With it at 1, `host_rdata` returns the control register: bit 0 transparent, bit 2 erase enable, all other bits 0. `dbg_rdata` returns the staging copy of `host_addr`.
- R10: When a transparent host write and a commit fall in the same cycle, the written register's active copy takes the write data. Every other register takes its staging value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_ctrl_sel | input | 1 | 1 selects the control register, 0 selects the bank |
| host_addr | input | ADDR_W | Register index within the bank |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Active copy or control register readback |
| dbg_rdata | output | DATA_W | Staging copy of the addressed register |
| ld_wr | input | 1 | Loader write strobe into staging |
| ld_addr | input | ADDR_W | Loader register index |
| ld_data | input | DATA_W | Loader data |
| ld_commit | input | 1 | Loader request to copy the whole bank to active |
| erase_req | input | 1 | Page-erase request from the command path |
| erase_grant | output | 1 | Erase request passed through the enable gate |
| active_flat | output | NUM_REGS*DATA_W | All active copies, register i at bits [i*DATA_W +: DATA_W] |

## Verification
The bank is driven with a seeded random mix of buffered writes, transparent writes, control commits, loader writes, loader commits and collisions between them. A reference model tracks both copies of every register. Buffered writes against transparent writes separate a stage-only update from an immediate one. Commits issued right after partial staging show whether the copy is bank-wide and uses the values from before the edge. Directed cases cover the rest:
- a loader write colliding with a host write;
- a commit arriving with a transparent write;
- readback of the self-clearing bit;
- erase requests with the enable both clear and set.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
   localparam int CTL_XPAR_BIT   = 0;
   localparam int CTL_COMMIT_BIT = 1;
   localparam int CTL_ERASE_BIT  = 2;
   localparam int CTL_MIN_W      = 3;

   typedef struct packed {
      logic xpar;
      logic erase_en;
   } ctl_state_t;
endpackage

// File: rtl/cfg_ctrl_reg.sv
module cfg_ctrl_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic wr_xpar,
   input  logic wr_commit,
   input  logic wr_erase,
   input  logic erase_req,
   output logic xpar,
   output logic erase_en,
   output logic commit_pulse,
   output logic erase_grant
);
   import cfg_bank_pkg::*;

   ctl_state_t st_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= '0;
      end else if (wr) begin
         st_q.xpar     <= wr_xpar;
         st_q.erase_en <= wr_erase;
      end
   end

   assign xpar         = st_q.xpar;
   assign erase_en     = st_q.erase_en;
   assign commit_pulse = wr & wr_commit;
   assign erase_grant  = erase_req & st_q.erase_en;

   AST_ERASE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      erase_grant |-> erase_en); // R6
   AST_CTL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (xpar == $past(wr_xpar)) && (erase_en == $past(wr_erase))); // R4
endmodule

// File: rtl/cfg_dbuf_cell.sv
module cfg_dbuf_cell #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stage_we,
   input  logic [DATA_W-1:0] stage_d,
   input  logic              act_we,
   input  logic [DATA_W-1:0] act_d,
   input  logic              commit,
   output logic [DATA_W-1:0] q_stage,
   output logic [DATA_W-1:0] q_act
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_stage <= '0;
         q_act   <= '0;
      end else begin
         if (stage_we) q_stage <= stage_d;
         if (act_we)      q_act <= act_d;
         else if (commit) q_act <= q_stage;
      end
   end

   AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_we && !commit) |=> $stable(q_act)); // R3
   AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !act_we) |=> (q_act == $past(q_stage))); // R4
   AST_XPAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      act_we |=> (q_act == $past(act_d))); // R10
   AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !stage_we |=> $stable(q_stage)); // R7
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux #(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 8,
   localparam int ADDR_W  = $clog2(NUM_REGS)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              ctrl_sel,
   input  logic [DATA_W-1:0] ctrl_word,
   input  logic [DATA_W-1:0] stage_arr [NUM_REGS],
   input  logic [DATA_W-1:0] act_arr   [NUM_REGS],
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] dbg
);
   logic [DATA_W-1:0] act_sel, stage_sel;

   always_comb begin
      act_sel   = '0;
      stage_sel = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (addr == ADDR_W'(i)) begin
            act_sel   = act_arr[i];
            stage_sel = stage_arr[i];
         end
      end
   end

   assign rdata = ctrl_sel ? ctrl_word : act_sel;
   assign dbg   = stage_sel;
endmodule

// File: rtl/cfg_bank_dbuf.sv
module cfg_bank_dbuf #(
   parameter int NUM_REGS = 16,
   parameter int DATA_W   = 8,
   localparam int ADDR_W  = $clog2(NUM_REGS),
   localparam int FLAT_W  = NUM_REGS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_ctrl_sel,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic [DATA_W-1:0] dbg_rdata,
   input  logic              ld_wr,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              ld_commit,
   input  logic              erase_req,
   output logic              erase_grant,
   output logic [FLAT_W-1:0] active_flat
);
   import cfg_bank_pkg::*;

   if (NUM_REGS < 2) begin : g_bad_depth
      $error("cfg_bank_dbuf: NUM_REGS must be at least 2");
   end
   if (DATA_W < CTL_MIN_W) begin : g_bad_width
      $error("cfg_bank_dbuf: DATA_W too narrow for the control bits");
   end

   logic xpar, erase_en, ctl_commit, commit_all;
   logic host_reg_wr, host_ctl_wr;
   logic [DATA_W-1:0] ctrl_word;
   logic [DATA_W-1:0] stage_arr [NUM_REGS];
   logic [DATA_W-1:0] act_arr   [NUM_REGS];

   assign host_ctl_wr = host_wr & host_ctrl_sel;
   assign host_reg_wr = host_wr & ~host_ctrl_sel & ~ld_wr;

   cfg_ctrl_reg u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr           (host_ctl_wr),
      .wr_xpar      (host_wdata[CTL_XPAR_BIT]),
      .wr_commit    (host_wdata[CTL_COMMIT_BIT]),
      .wr_erase     (host_wdata[CTL_ERASE_BIT]),
      .erase_req    (erase_req),
      .xpar         (xpar),
      .erase_en     (erase_en),
      .commit_pulse (ctl_commit),
      .erase_grant  (erase_grant)
   );

   assign commit_all = ctl_commit | ld_commit;

   always_comb begin
      ctrl_word                 = '0;
      ctrl_word[CTL_XPAR_BIT]   = xpar;
      ctrl_word[CTL_ERASE_BIT]  = erase_en;
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
      logic hit_host, hit_ld;
      assign hit_host = host_reg_wr && (host_addr == ADDR_W'(g));
      assign hit_ld   = ld_wr && (ld_addr == ADDR_W'(g));

      cfg_dbuf_cell #(.DATA_W(DATA_W)) u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .stage_we (hit_ld | hit_host),
         .stage_d  (ld_wr ? ld_data : host_wdata),
         .act_we   (hit_host & xpar),
         .act_d    (host_wdata),
         .commit   (commit_all),
         .q_stage  (stage_arr[g]),
         .q_act    (act_arr[g])
      );

      assign active_flat[g*DATA_W +: DATA_W] = act_arr[g];
   end

   cfg_read_mux #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rmux (
      .addr      (host_addr),
      .ctrl_sel  (host_ctrl_sel),
      .ctrl_word (ctrl_word),
      .stage_arr (stage_arr),
      .act_arr   (act_arr),
      .rdata     (host_rdata),
      .dbg       (dbg_rdata)
   );

   AST_CTL_BIT1_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      host_ctrl_sel |-> (host_rdata[CTL_COMMIT_BIT] == 1'b0)); // R5
   AST_LD_BLOCKS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_wr && host_wr && !host_ctrl_sel && !commit_all) |=> $stable(active_flat)); // R7
endmodule

// File: tb/cfg_bank_dbuf_tb.sv
module cfg_bank_dbuf_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NR = 16;
   localparam int DW = 8;
   localparam int AW = 4;

   logic clk = 1'b0;
   logic rst_n;
   logic host_wr, host_ctrl_sel, ld_wr, ld_commit, erase_req;
   logic [AW-1:0] host_addr, ld_addr;
   logic [DW-1:0] host_wdata, ld_data, host_rdata, dbg_rdata;
   logic erase_grant;
   logic [NR*DW-1:0] active_flat;

   logic [DW-1:0] m_a [NR];
   logic [DW-1:0] m_b [NR];
   logic m_x, m_e;
   int checks = 0, errors = 0;
   string tag;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_bank_dbuf #(.NUM_REGS(NR), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_ctrl_sel(host_ctrl_sel),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .dbg_rdata(dbg_rdata), .ld_wr(ld_wr), .ld_addr(ld_addr), .ld_data(ld_data),
      .ld_commit(ld_commit), .erase_req(erase_req), .erase_grant(erase_grant),
      .active_flat(active_flat)
   );

   function automatic logic [DW-1:0] exp_ctrl();
      logic [DW-1:0] v = '0;
      v[0] = m_x;
      v[2] = m_e;
      return v;
   endfunction

   task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
      end
   endtask

   task automatic chk_active(string t);
      for (int i = 0; i < NR; i++)
         chk(t, 32'(active_flat[i*DW +: DW]), 32'(m_b[i]));
   endtask

   // drive at negedge, check combinational reads, advance model, cross the edge
   task automatic cycle(logic hw, logic hs, logic [AW-1:0] ha, logic [DW-1:0] hd,
                        logic lw, logic [AW-1:0] la, logic [DW-1:0] ldd,
                        logic lc, logic er);
      logic [DW-1:0] nb [NR];
      logic commit, regwr;
      host_wr = hw; host_ctrl_sel = hs; host_addr = ha; host_wdata = hd;
      ld_wr = lw; ld_addr = la; ld_data = ldd; ld_commit = lc; erase_req = er;
      #1;
      if (hs) begin
         chk("R9 ctrl read", 32'(host_rdata), 32'(exp_ctrl()));
         chk("R5 bit1 readback", 32'(host_rdata[1]), 32'd0);
      end else begin
         chk("R9 active read", 32'(host_rdata), 32'(m_b[ha]));
      end
      chk("R9 staging read", 32'(dbg_rdata), 32'(m_a[ha]));
      chk("R6 erase gate", 32'(erase_grant), 32'(er & m_e));
      // model next state
      commit = (hw && hs && hd[1]) || lc;
      regwr  = hw && !hs && !lw;
      tag = lw ? "R7" : "R3";
      for (int i = 0; i < NR; i++) nb[i] = commit ? m_a[i] : m_b[i];
      if (commit) tag = lc ? "R8" : "R4";
      if (regwr && m_x) begin
         nb[ha] = hd;
         tag = commit ? "R10" : "R2";
      end
      if (regwr) m_a[ha] = hd;
      if (lw) m_a[la] = ldd;
      for (int i = 0; i < NR; i++) m_b[i] = nb[i];
      if (hw && hs) begin m_x = hd[0]; m_e = hd[2]; end
      @(posedge clk);
      @(negedge clk);
      chk_active(tag);
   endtask

   task automatic idle();
      cycle(0, 0, '0, '0, 0, '0, '0, 0, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++; errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < NR; i++) begin m_a[i] = '0; m_b[i] = '0; end
      m_x = 0; m_e = 0;
      rst_n = 0;
      host_wr = 0; host_ctrl_sel = 0; host_addr = '0; host_wdata = '0;
      ld_wr = 0; ld_addr = '0; ld_data = '0; ld_commit = 0; erase_req = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk_active("R1");
      host_ctrl_sel = 1; #1;
      chk("R1 ctrl after reset", 32'(host_rdata), 32'd0);
      host_ctrl_sel = 0;
      for (int i = 0; i < NR; i++) begin
         host_addr = AW'(i); #1;
         chk("R1 staging after reset", 32'(dbg_rdata), 32'd0);
      end

      // R3 buffered write, then R4 commit with bit1 set (reads back 0, R5)
      cycle(1, 0, 4'd3, 8'hA5, 0, '0, '0, 0, 0);
      cycle(0, 0, 4'd3, '0, 0, '0, '0, 0, 0);
      cycle(1, 1, '0, 8'h02, 0, '0, '0, 0, 0);
      cycle(0, 1, '0, '0, 0, '0, '0, 0, 0);
      // R6 erase blocked then granted
      cycle(0, 0, '0, '0, 0, '0, '0, 0, 1);
      cycle(1, 1, '0, 8'h04, 0, '0, '0, 0, 1);
      cycle(0, 0, '0, '0, 0, '0, '0, 0, 1);
      // R2 transparent write
      cycle(1, 1, '0, 8'h05, 0, '0, '0, 0, 0);
      cycle(1, 0, 4'd7, 8'h3C, 0, '0, '0, 0, 0);
      // R7 loader collides with host write while transparent
      cycle(1, 0, 4'd9, 8'h11, 1, 4'd9, 8'h99, 0, 0);
      cycle(0, 0, 4'd9, '0, 0, '0, '0, 0, 0);
      // R10 transparent write with loader commit
      cycle(1, 0, 4'd1, 8'h77, 1, 4'd2, 8'h22, 0, 0);
      cycle(1, 0, 4'd5, 8'hEE, 0, '0, '0, 1, 0);
      // R8 loader fill then commit, buffered mode
      cycle(1, 1, '0, 8'h00, 0, '0, '0, 0, 0);
      for (int i = 0; i < NR; i++) cycle(0, 0, AW'(i), '0, 1, AW'(i), DW'(i*17+1), 0, 0);
      cycle(0, 0, '0, '0, 0, '0, '0, 1, 0);

      // random mix
      for (int n = 0; n < 3000; n++) begin
         int op = $urandom_range(0, 15);
         logic [AW-1:0] a = AW'($urandom);
         logic [DW-1:0] d = DW'($urandom);
         logic [AW-1:0] la = AW'($urandom);
         logic [DW-1:0] ldd = DW'($urandom);
         logic er = 1'($urandom);
         case (op)
            0, 1, 2, 3, 4: cycle(1, 0, a, d, 0, la, ldd, 0, er);
            5:             cycle(1, 1, a, d & 8'h07, 0, la, ldd, 0, er);
            6, 7:          cycle(0, 0, a, d, 1, la, ldd, 0, er);
            8:             cycle(1, 0, a, d, 1, la, ldd, 0, er);
            9:             cycle(0, 0, a, d, 0, la, ldd, 1, er);
            10:            cycle(1, 0, a, d, 0, la, ldd, 1, er);
            11:            cycle(0, 1, a, d, 0, la, ldd, 0, er);
            default:       cycle(0, 0, a, d, 0, la, ldd, 0, er);
         endcase
      end
      idle();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule